// File: doc/BRIEF.md
# Read-Back Capture Latch Register

This block stores one word taken from a shared data bus and can place that stored word back onto the same bus. While the load control is high, the stored word tracks the bus. When the load control goes low, the last value is kept. A second port presents the stored word to downstream logic. A build-time option selects whether that port shows the word as stored or bit-inverted. That port is released unless two active-low enables are both asserted. A separate active-low read-back control drives the stored word, always in true polarity, onto the input bus. Two active-low force inputs set the word to all zeros or all ones at once. Zeros win when both are asserted.

Inside a chip, every tri-stated pin is a triple of data in, data out and a drive-enable. A low drive-enable means the line is released (high impedance). The surrounding pad logic or bus fabric resolves the lines. A parameter selects the storage style. The default is a clocked register that captures the bus on each rising clock edge while the load control is high. The other style is a level-sensitive latch. The force inputs act combinationally on both ports in either style. In the clocked style, a force must be held across one clock edge for its value to remain in storage after it is released.

Top module: `rbl_latch_reg`

## Requirements
- R1: In the clocked style, when `load_en` is 1 at a rising edge of `clk`, the stored word takes the value of `bus_in`. The new word appears on `rb_data` and on `out_data` right after that edge.
- R2: When `load_en` is 0 at a rising edge and no force is asserted, the stored word is unchanged, whatever `bus_in` carries.
- R3: `out_en` is 1 only when both `out_en_a_n` and `out_en_b_n` are 0. If either of them is 1, `out_en` is 0 and the output port is released.
- R4: `rb_en` is 1 exactly when `rb_n` is 0. `rb_data` always carries the stored word.
- R5: `rb_n` has no effect on the stored word. With read-back on and `load_en` high, the block captures its own word from the bus and the word does not change.
- R6: With `INVERT_OUT` = 1, `out_data` is the bitwise inverse of the stored word. With `INVERT_OUT` = 0, `out_data` equals the stored word.
- R7: When `clr_n` is 0, the stored word reads as all zeros on both ports at once, without waiting for a clock edge and whatever `load_en` is.
- R8: When `pre_n` is 0 and `clr_n` is 1, the stored word reads as all ones at once. A load that is active at the same time does not take effect.
- R9: When `clr_n` and `pre_n` are both 0, the stored word is all zeros.
- R10: If a force is held across a rising edge and then released while `load_en` is 0, the forced value stays in storage.
- R11: `rb_data` carries the stored word in true polarity for both settings of `INVERT_OUT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the clocked storage style |
| load_en | input | 1 | Active-high load control: storage follows the bus while high |
| clr_n | input | 1 | Active-low force to all zeros (takes priority) |
| pre_n | input | 1 | Active-low force to all ones |
| out_en_a_n | input | 1 | First active-low enable of the output port |
| out_en_b_n | input | 1 | Second active-low enable of the output port |
| rb_n | input | 1 | Active-low read-back control for the bus driver |
| bus_in | input | WIDTH | Resolved value of the shared data bus |
| rb_data | output | WIDTH | Stored word (true polarity) for the bus driver |
| rb_en | output | 1 | Bus driver enable; 0 means the bus line is released |
| out_data | output | WIDTH | Output port word, true or inverted |
| out_en | output | 1 | Output port enable; 0 means the port is released |

## Verification
The load path is tried with complementary checkerboard words (A5, 5A), all ones and all zeros. These show whether any bit is stuck, swapped or dropped. Hold cycles put a different word on the bus while the load control is low, which separates a held word from a transparent one. Every enable pair for the output port is stepped through. Read-back is turned on both while holding and while loading, so a design that lets read-back disturb storage can be told apart from one that does not. Two instances with opposite polarity run side by side, so an inversion that leaked into the read-back path would show up. Forces are applied alone, together, against an active load and then released, which separates a combinational override from a clocked one and checks which force has priority.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
   typedef enum logic {
      IMPL_FLOP  = 1'b0,
      IMPL_LATCH = 1'b1
   } rbl_impl_e;
endpackage

// File: rtl/rbl_force.sv
// Resolves the two asynchronous force inputs; zeros beat ones.
module rbl_force #(
   parameter int WIDTH = 8
) (
   input  logic             clr_n,
   input  logic             pre_n,
   input  logic [WIDTH-1:0] raw_word,
   output logic             force_any,
   output logic [WIDTH-1:0] force_word,
   output logic [WIDTH-1:0] eff_word
);
   localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ALL_ZEROS = {WIDTH{1'b0}};

   always_comb begin
      force_any  = !clr_n || !pre_n;
      force_word = (!clr_n) ? ALL_ZEROS : ALL_ONES;
      eff_word   = force_any ? force_word : raw_word;
   end
endmodule

// File: rtl/rbl_store.sv
// Word storage: clocked register or level-sensitive latch, chosen by IMPL.
module rbl_store
   import rbl_pkg::*;
#(
   parameter int        WIDTH = 8,
   parameter rbl_impl_e IMPL  = IMPL_FLOP
) (
   input  logic             clk,
   input  logic             load_en,
   input  logic             force_any,
   input  logic [WIDTH-1:0] force_word,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] word_q
);
   generate
      if (IMPL == IMPL_FLOP) begin : g_flop
         logic [WIDTH-1:0] st_q;
         always_ff @(posedge clk) begin
            if (force_any) begin
               st_q <= force_word;
            end else if (load_en) begin
               st_q <= d_in;
            end
         end
         assign word_q = st_q;
      end else begin : g_latch
         logic [WIDTH-1:0] st_l;
         always_latch begin
            if (force_any) begin
               st_l = force_word;
            end else if (load_en) begin
               st_l = d_in;
            end
         end
         assign word_q = st_l;
      end
   endgenerate
endmodule

// File: rtl/rbl_drive.sv
// Port drivers: polarity option on the output port, true word on read-back.
module rbl_drive #(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b0
) (
   input  logic [WIDTH-1:0] word,
   input  logic             out_en_a_n,
   input  logic             out_en_b_n,
   input  logic             rb_n,
   output logic [WIDTH-1:0] out_data,
   output logic             out_en,
   output logic [WIDTH-1:0] rb_data,
   output logic             rb_en
);
   generate
      if (INVERT_OUT) begin : g_inv
         assign out_data = ~word;
      end else begin : g_true
         assign out_data = word;
      end
   endgenerate

   assign out_en  = ~(out_en_a_n | out_en_b_n);
   assign rb_data = word;
   assign rb_en   = ~rb_n;
endmodule

// File: rtl/rbl_latch_reg.sv
module rbl_latch_reg
   import rbl_pkg::*;
#(
   parameter int        WIDTH      = 8,
   parameter bit        INVERT_OUT = 1'b0,
   parameter rbl_impl_e IMPL       = IMPL_FLOP
) (
   input  logic             clk,
   input  logic             load_en,
   input  logic             clr_n,
   input  logic             pre_n,
   input  logic             out_en_a_n,
   input  logic             out_en_b_n,
   input  logic             rb_n,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] rb_data,
   output logic             rb_en,
   output logic [WIDTH-1:0] out_data,
   output logic             out_en
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rbl_latch_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic             force_any;
   logic [WIDTH-1:0] force_word;
   logic [WIDTH-1:0] raw_word;
   logic [WIDTH-1:0] eff_word;

   rbl_store #(.WIDTH(WIDTH), .IMPL(IMPL)) store_i (
      .clk        (clk),
      .load_en    (load_en),
      .force_any  (force_any),
      .force_word (force_word),
      .d_in       (bus_in),
      .word_q     (raw_word)
   );

   rbl_force #(.WIDTH(WIDTH)) force_i (
      .clr_n      (clr_n),
      .pre_n      (pre_n),
      .raw_word   (raw_word),
      .force_any  (force_any),
      .force_word (force_word),
      .eff_word   (eff_word)
   );

   rbl_drive #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT)) drive_i (
      .word       (eff_word),
      .out_en_a_n (out_en_a_n),
      .out_en_b_n (out_en_b_n),
      .rb_n       (rb_n),
      .out_data   (out_data),
      .out_en     (out_en),
      .rb_data    (rb_data),
      .rb_en      (rb_en)
   );
endmodule

// File: rtl/rbl_latch_chk.sv
module rbl_latch_chk #(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b0
) (
   input logic             clk,
   input logic             load_en,
   input logic             clr_n,
   input logic             pre_n,
   input logic             out_en_a_n,
   input logic             out_en_b_n,
   input logic             rb_n,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] rb_data,
   input logic             rb_en,
   input logic [WIDTH-1:0] out_data,
   input logic             out_en
);
   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
      load_en |=> (rb_data == $past(bus_in)));  // R1
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
      !load_en |=> $stable(rb_data));  // R2
   AST_OUT_RELEASED: assert property (@(posedge clk) disable iff (!clr_n)
      (out_en_a_n || out_en_b_n) |-> !out_en);  // R3
   AST_RB_RELEASED: assert property (@(posedge clk) disable iff (!clr_n)
      rb_n |-> !rb_en);  // R4
   AST_POLARITY: assert property (@(posedge clk) disable iff (!clr_n)
      out_data == (INVERT_OUT ? ~rb_data : rb_data));  // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk)
      !clr_n |-> (rb_data == {WIDTH{1'b0}}));  // R9
   AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!clr_n)
      !pre_n |-> (rb_data == {WIDTH{1'b1}}));  // R8
endmodule

bind rbl_latch_reg rbl_latch_chk #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT)) chk_i (
   .clk        (clk),
   .load_en    (load_en),
   .clr_n      (clr_n),
   .pre_n      (pre_n),
   .out_en_a_n (out_en_a_n),
   .out_en_b_n (out_en_b_n),
   .rb_n       (rb_n),
   .bus_in     (bus_in),
   .rb_data    (rb_data),
   .rb_en      (rb_en),
   .out_data   (out_data),
   .out_en     (out_en)
);

// File: tb/rbl_latch_reg_tb_top.sv
module rbl_latch_reg_tb_top;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         load_en = 1'b0, clr_n = 1'b0, pre_n = 1'b1;
   logic         oea_n = 1'b1, oeb_n = 1'b1, rb_n = 1'b1;
   logic         ext_drv = 1'b0;
   logic [W-1:0] ext_val = '0;
   logic [W-1:0] bus;
   logic [W-1:0] rb_d, out_d, rb_d_i, out_d_i;
   logic         rb_e, out_e, rb_e_i, out_e_i;

   assign bus = rb_e ? rb_d : ext_val;

   rbl_latch_reg #(.WIDTH(W), .INVERT_OUT(1'b0)) dut_i (
      .clk(clk), .load_en(load_en), .clr_n(clr_n), .pre_n(pre_n),
      .out_en_a_n(oea_n), .out_en_b_n(oeb_n), .rb_n(rb_n), .bus_in(bus),
      .rb_data(rb_d), .rb_en(rb_e), .out_data(out_d), .out_en(out_e));

   rbl_latch_reg #(.WIDTH(W), .INVERT_OUT(1'b1)) dut_inv_i (
      .clk(clk), .load_en(load_en), .clr_n(clr_n), .pre_n(pre_n),
      .out_en_a_n(oea_n), .out_en_b_n(oeb_n), .rb_n(rb_n), .bus_in(bus),
      .rb_data(rb_d_i), .rb_en(rb_e_i), .out_data(out_d_i), .out_en(out_e_i));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Checks both instances against an expected stored word and enables.
   task automatic check_word(input string req, input logic [W-1:0] w,
                             input bit exp_oen, input bit exp_rben);
      check(rb_d == w, {req, " rb_data"}, rb_d, w);
      check(rb_d_i == w, {req, " R11 rb_data inverted inst"}, rb_d_i, w);
      check(out_e == exp_oen, {req, " R3 out_en"}, W'(out_e), W'(exp_oen));
      check(out_e_i == exp_oen, {req, " R3 out_en inv"}, W'(out_e_i), W'(exp_oen));
      check(rb_e == exp_rben, {req, " R4 rb_en"}, W'(rb_e), W'(exp_rben));
      check(!(rb_e && ext_drv), {req, " R4 bus contention"}, W'(rb_e), W'(0));
      if (exp_oen) begin
         check(out_d == w, {req, " R6 out_data true"}, out_d, w);
         check(out_d_i == ~w, {req, " R6 out_data inverted"}, out_d_i, ~w);
      end
   endtask

   // Vector: {load_en, rb_n, oea_n, oeb_n, bus_word[7:0], exp_word[7:0]}
   localparam int NV = 11;
   localparam logic [19:0] VEC [NV] = '{
      {4'b1100, 8'hA5, 8'hA5},   // R1 load
      {4'b0100, 8'h3C, 8'hA5},   // R2 hold
      {4'b0110, 8'h3C, 8'hA5},   // R3 enable a off
      {4'b0101, 8'h3C, 8'hA5},   // R3 enable b off
      {4'b0111, 8'h3C, 8'hA5},   // R3 both off
      {4'b1100, 8'h5A, 8'h5A},   // R1 load
      {4'b0000, 8'hFF, 8'h5A},   // R5 read-back while holding
      {4'b1000, 8'h00, 8'h5A},   // R5 read-back while loading
      {4'b1100, 8'hFF, 8'hFF},   // R1 all ones
      {4'b1100, 8'h00, 8'h00},   // R1 all zeros
      {4'b0100, 8'hC3, 8'h00}    // R2 hold zeros
   };

   initial begin
      // R7 reset state: clear held from time zero
      #1;
      check_word("R7 reset", 8'h00, 1'b0, 1'b0);
      @(negedge clk);
      oea_n = 1'b0; oeb_n = 1'b0;
      @(posedge clk); #1;
      check_word("R7 reset held", 8'h00, 1'b1, 1'b0);
      @(negedge clk);
      clr_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         load_en = VEC[i][19];
         rb_n    = VEC[i][18];
         oea_n   = VEC[i][17];
         oeb_n   = VEC[i][16];
         ext_drv = VEC[i][18];
         ext_val = VEC[i][15:8];
         @(posedge clk); #1;
         check_word($sformatf("vec%0d R1 R2", i), VEC[i][7:0],
                    !(VEC[i][17] | VEC[i][16]), !VEC[i][18]);
      end

      // Load 96, then clear without a clock edge (R7)
      @(negedge clk);
      rb_n = 1'b1; ext_drv = 1'b1; oea_n = 1'b0; oeb_n = 1'b0;
      load_en = 1'b1; ext_val = 8'h96;
      @(posedge clk); #1;
      check_word("R1 load 96", 8'h96, 1'b1, 1'b0);
      @(negedge clk);
      load_en = 1'b0; ext_val = 8'h11;
      clr_n = 1'b0;
      #1;
      check_word("R7 immediate clear", 8'h00, 1'b1, 1'b0);
      @(posedge clk); #1;
      @(negedge clk);
      clr_n = 1'b1;
      #1;
      check_word("R10 clear retained", 8'h00, 1'b1, 1'b0);
      @(posedge clk); #1;
      check_word("R10 clear retained after edge", 8'h00, 1'b1, 1'b0);

      // Preset against an active load (R8), then release (R10)
      @(negedge clk);
      load_en = 1'b1; ext_val = 8'h12;
      pre_n = 1'b0;
      #1;
      check_word("R8 immediate preset", 8'hFF, 1'b1, 1'b0);
      @(posedge clk); #1;
      check_word("R8 preset beats load", 8'hFF, 1'b1, 1'b0);
      @(negedge clk);
      load_en = 1'b0;
      @(posedge clk); #1;
      @(negedge clk);
      pre_n = 1'b1;
      @(posedge clk); #1;
      check_word("R10 preset retained", 8'hFF, 1'b1, 1'b0);

      // Both forces: zeros win (R9)
      @(negedge clk);
      pre_n = 1'b0; clr_n = 1'b0;
      #1;
      check_word("R9 both forces", 8'h00, 1'b1, 1'b0);
      @(posedge clk); #1;
      check_word("R9 both forces after edge", 8'h00, 1'b1, 1'b0);
      @(negedge clk);
      clr_n = 1'b1;
      #1;
      check_word("R8 preset after clear drops", 8'hFF, 1'b1, 1'b0);
      @(posedge clk); #1;
      @(negedge clk);
      pre_n = 1'b1;

      // Read-back of forced ones while polarity differs (R11)
      rb_n = 1'b0; ext_drv = 1'b0;
      #1;
      check_word("R11 read-back forced word", 8'hFF, 1'b1, 1'b1);
      @(posedge clk); #1;
      @(negedge clk);
      rb_n = 1'b1; ext_drv = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule